// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out and takes back aligned blocks of a 1024-unit region (the size is set by a parameter). All blocks are powers of two in size. An allocate request carries a unit count. The block rounds the count up to the next power of two. It picks the smallest free block that can hold it and halves that block as many times as needed, always keeping the lower half. It then returns the base address of the granted block. A free request carries a base address. The block marks the block free, then joins it with its buddy, and keeps joining at each larger size while the buddy is also free.

Bookkeeping is a heap-ordered binary tree with one two-bit status per node. A node is absent, free, split or used. Requests use a valid/busy handshake. A request is taken when `req_valid_i` is high and `busy_o` is low. Each accepted request ends with a one-cycle response that carries the granted address and either an out-of-memory flag or an error flag. The block stores no data.

Top module: `buddy_alloc`

## Requirements
- R1: After reset the whole region is one free block: `busy_o` and `rsp_valid_o` are low, and a 1024-unit request is granted at address 0.
- R2: An allocation is served with a block of the smallest power of two that is at least the requested count; a count of 0 is served as 1 unit.
- R3: Among free blocks, the smallest size class that fits is used first, and within that class the lowest address is used (allocate 70, 35, 80, free 0, allocate 60 gives 0, 128, 256, then 192).
- R4: When no free block of the exact size exists, a larger free block is halved repeatedly; the lower half is kept for further splitting or granting and the upper half stays free.
- R5: A freed block merges with its free buddy repeatedly; once every block is freed, a 1024-unit request is again granted at address 0.
- R6: A request larger than the largest free block, or larger than the region, responds with `rsp_oom_o` high and changes no state.
- R7: Freeing an address that is not the base of a used block responds with `rsp_err_o` high and changes no state. This covers a misaligned address inside a used block, a free block, and a double free.
- R8: A request is accepted only while `busy_o` is low. `busy_o` is high from the cycle after acceptance until the response. `rsp_valid_o` is a single-cycle pulse with `busy_o` low. Requests raised while busy are ignored.
- R9: Every granted address is a multiple of the granted block size.
- R10: Rounding waste is not an error: a request of 65 units is granted 128 units with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_free_i | input | 1 | 1 = free request, 0 = allocate request |
| req_size_i | input | ADDR_W+1 | Unit count for allocate |
| req_addr_i | input | ADDR_W | Block base for free |
| busy_o | output | 1 | Request in progress; new requests ignored |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_addr_o | output | ADDR_W | Granted base (allocate) or echoed base (free) |
| rsp_oom_o | output | 1 | Allocation could not be served |
| rsp_err_o | output | 1 | Free address was not a used block base |

## Verification
A wrong status bit in the tree does not stay hidden. It shows up as a wrong grant address on the next allocation that reaches that part of the tree. A missed merge shows up as an out-of-memory response to a full-region request right after every block is freed. A lost used mark shows up as the same address granted twice, or as a double free that is accepted silently. Each scenario therefore ends with a full-region allocation. This exposes any leftover corruption within one request's latency, and every grant is compared with a hand-derived address.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
  typedef enum logic [1:0] {
    ND_ABSENT = 2'd0,
    ND_FREE   = 2'd1,
    ND_SPLIT  = 2'd2,
    ND_USED   = 2'd3
  } node_st_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SEARCH, S_SPLIT, S_CLIMB, S_MERGE, S_OOM
  } ctrl_st_e;
endpackage

// File: rtl/buddy_size_round.sv
module buddy_size_round #(
  parameter int ADDR_W = 10,
  parameter int LVL_W  = $clog2(ADDR_W + 2)
) (
  input  logic [ADDR_W:0]   size_i,
  output logic [LVL_W-1:0]  order_o,
  output logic              too_big_o
);
  logic [ADDR_W+1:0] lim;

  // smallest k with size <= 2^k
  always_comb begin
    order_o   = LVL_W'(ADDR_W + 1);
    too_big_o = 1'b1;
    lim       = '0;
    for (int k = ADDR_W; k >= 0; k--) begin
      lim = (ADDR_W+2)'(1) << k;
      if ((ADDR_W+2)'(size_i) <= lim) begin
        order_o   = LVL_W'(k);
        too_big_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/buddy_tree_mem.sv
module buddy_tree_mem
  import buddy_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = ADDR_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IDX_W-1:0]       ra_idx_i,
  output logic [1:0]             ra_st_o,
  input  logic [IDX_W-1:0]       rb_idx_i,
  output logic [1:0]             rb_st_o,
  input  logic [2:0]             we_i,
  input  logic [2:0][IDX_W-1:0]  wr_idx_i,
  input  logic [2:0][1:0]        wr_st_i
);
  localparam int NODES = 2 ** IDX_W;

  logic [1:0] st_q [NODES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NODES; n++)
        st_q[n] <= (n == 1) ? 2'(ND_FREE) : 2'(ND_ABSENT);
    end else begin
      for (int w = 0; w < 3; w++)
        if (we_i[w]) st_q[wr_idx_i[w]] <= wr_st_i[w];
    end
  end

  assign ra_st_o = st_q[ra_idx_i];
  assign rb_st_o = st_q[rb_idx_i];

  // R5
  root_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[1] != 2'(ND_ABSENT));

  // R4
  wr_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i[0] && we_i[1]) |-> (wr_idx_i[0] != wr_idx_i[1]));
endmodule

// File: rtl/buddy_ctrl.sv
module buddy_ctrl
  import buddy_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = ADDR_W + 1,
  parameter int LVL_W  = $clog2(ADDR_W + 2)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_free_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [LVL_W-1:0]       req_order_i,
  input  logic                   req_too_big_i,
  output logic [IDX_W-1:0]       ra_idx_o,
  input  logic [1:0]             ra_st_i,
  output logic [IDX_W-1:0]       rb_idx_o,
  input  logic [1:0]             rb_st_i,
  output logic [2:0]             we_o,
  output logic [2:0][IDX_W-1:0]  wr_idx_o,
  output logic [2:0][1:0]        wr_st_o,
  output logic                   busy_o,
  output logic                   rsp_valid_o,
  output logic [ADDR_W-1:0]      rsp_addr_o,
  output logic                   rsp_oom_o,
  output logic                   rsp_err_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(ADDR_W);

  ctrl_st_e           st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [LVL_W-1:0]   lvl_q, tgt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               was_alloc_q;
  logic               rsp_valid_q, rsp_oom_q, rsp_err_q;
  logic [ADDR_W-1:0]  rsp_addr_q;

  function automatic logic [IDX_W-1:0] lvl_first(input logic [LVL_W-1:0] l);
    return IDX_W'(1) << (TOP_LVL - l);
  endfunction

  function automatic logic [ADDR_W-1:0] base_of(input logic [IDX_W-1:0] i,
                                                input logic [LVL_W-1:0] l);
    return ADDR_W'((i & ~lvl_first(l)) << l);
  endfunction

  logic [IDX_W-1:0] pos_c, first_c;
  logic             last_c, buddy_free_c, aligned_c;

  assign first_c      = lvl_first(lvl_q);
  assign pos_c        = idx_q & ~first_c;
  assign last_c       = (pos_c == first_c - IDX_W'(1));
  assign buddy_free_c = (lvl_q < TOP_LVL) && (rb_st_i == 2'(ND_FREE));
  assign aligned_c    = (({1'b0, addr_q} & ((IDX_W'(1) << lvl_q) - IDX_W'(1))) == '0);

  assign ra_idx_o = idx_q;
  assign rb_idx_o = idx_q ^ IDX_W'(1);

  always_comb begin
    we_o     = '0;
    wr_idx_o = '0;
    wr_st_o  = '0;
    unique case (st_q)
      S_SEARCH: if (ra_st_i == 2'(ND_FREE) && lvl_q == tgt_q) begin
        we_o[0] = 1'b1; wr_idx_o[0] = idx_q; wr_st_o[0] = ND_USED;
      end
      S_SPLIT: begin
        we_o        = 3'b111;
        wr_idx_o[0] = idx_q;                 wr_st_o[0] = ND_SPLIT;
        wr_idx_o[1] = idx_q << 1;
        wr_st_o[1]  = (lvl_q - LVL_W'(1) == tgt_q) ? 2'(ND_USED) : 2'(ND_FREE);
        wr_idx_o[2] = (idx_q << 1) | IDX_W'(1); wr_st_o[2] = ND_FREE;
      end
      S_MERGE: begin
        if (buddy_free_c) begin
          we_o        = 3'b111;
          wr_idx_o[0] = idx_q;              wr_st_o[0] = ND_ABSENT;
          wr_idx_o[1] = idx_q ^ IDX_W'(1);  wr_st_o[1] = ND_ABSENT;
          wr_idx_o[2] = idx_q >> 1;         wr_st_o[2] = ND_FREE;
        end else begin
          we_o[0] = 1'b1; wr_idx_o[0] = idx_q; wr_st_o[0] = ND_FREE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      idx_q       <= IDX_W'(1);
      lvl_q       <= '0;
      tgt_q       <= '0;
      addr_q      <= '0;
      was_alloc_q <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_oom_q   <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_addr_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_oom_q   <= 1'b0;
      rsp_err_q   <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          was_alloc_q <= !req_free_i;
          if (req_free_i) begin
            addr_q <= req_addr_i;
            idx_q  <= {1'b1, req_addr_i};
            lvl_q  <= '0;
            st_q   <= S_CLIMB;
          end else if (req_too_big_i) begin
            st_q <= S_OOM;
          end else begin
            tgt_q <= req_order_i;
            lvl_q <= req_order_i;
            idx_q <= lvl_first(req_order_i);
            st_q  <= S_SEARCH;
          end
        end
        S_OOM: begin
          rsp_valid_q <= 1'b1;
          rsp_oom_q   <= 1'b1;
          st_q        <= S_IDLE;
        end
        S_SEARCH: begin
          if (ra_st_i == 2'(ND_FREE)) begin
            if (lvl_q == tgt_q) begin
              rsp_valid_q <= 1'b1;
              rsp_addr_q  <= base_of(idx_q, lvl_q);
              st_q        <= S_IDLE;
            end else begin
              st_q <= S_SPLIT;
            end
          end else if (last_c) begin
            if (lvl_q == TOP_LVL) begin
              rsp_valid_q <= 1'b1;
              rsp_oom_q   <= 1'b1;
              st_q        <= S_IDLE;
            end else begin
              lvl_q <= lvl_q + LVL_W'(1);
              idx_q <= lvl_first(lvl_q + LVL_W'(1));
            end
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        S_SPLIT: begin
          idx_q <= idx_q << 1;
          lvl_q <= lvl_q - LVL_W'(1);
          if (lvl_q - LVL_W'(1) == tgt_q) begin
            rsp_valid_q <= 1'b1;
            rsp_addr_q  <= base_of(idx_q, lvl_q);
            st_q        <= S_IDLE;
          end
        end
        S_CLIMB: begin
          if (ra_st_i == 2'(ND_ABSENT)) begin
            idx_q <= idx_q >> 1;
            lvl_q <= lvl_q + LVL_W'(1);
          end else if (ra_st_i == 2'(ND_USED) && aligned_c) begin
            st_q <= S_MERGE;
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= 1'b1;
            rsp_addr_q  <= addr_q;
            st_q        <= S_IDLE;
          end
        end
        S_MERGE: begin
          if (buddy_free_c) begin
            idx_q <= idx_q >> 1;
            lvl_q <= lvl_q + LVL_W'(1);
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_addr_q  <= addr_q;
            st_q        <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_addr_o  = rsp_addr_q;
  assign rsp_oom_o   = rsp_oom_q;
  assign rsp_err_o   = rsp_err_q;

  // R8
  rsp_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !busy_o);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);

  // R6
  flag_needs_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_oom_o || rsp_err_o) |-> rsp_valid_o);

  // R9
  grant_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && was_alloc_q && !rsp_oom_o)
      |-> (({1'b0, rsp_addr_o} & ((IDX_W'(1) << tgt_q) - IDX_W'(1))) == '0));

  // R4
  search_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SEARCH || st_q == S_SPLIT) |-> (lvl_q <= TOP_LVL && lvl_q >= tgt_q));
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_free_i,
  input  logic [ADDR_W:0]   req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              rsp_oom_o,
  output logic              rsp_err_o
);
  localparam int IDX_W = ADDR_W + 1;
  localparam int LVL_W = $clog2(ADDR_W + 2);

  logic [LVL_W-1:0]       order;
  logic                   too_big;
  logic [IDX_W-1:0]       ra_idx, rb_idx;
  logic [1:0]             ra_st, rb_st;
  logic [2:0]             we;
  logic [2:0][IDX_W-1:0]  wr_idx;
  logic [2:0][1:0]        wr_st;

  buddy_size_round #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_round (
    .size_i    (req_size_i),
    .order_o   (order),
    .too_big_o (too_big)
  );

  buddy_tree_mem #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tree (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_idx_i (ra_idx),
    .ra_st_o  (ra_st),
    .rb_idx_i (rb_idx),
    .rb_st_o  (rb_st),
    .we_i     (we),
    .wr_idx_i (wr_idx),
    .wr_st_i  (wr_st)
  );

  buddy_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_free_i    (req_free_i),
    .req_addr_i    (req_addr_i),
    .req_order_i   (order),
    .req_too_big_i (too_big),
    .ra_idx_o      (ra_idx),
    .ra_st_i       (ra_st),
    .rb_idx_o      (rb_idx),
    .rb_st_i       (rb_st),
    .we_o          (we),
    .wr_idx_o      (wr_idx),
    .wr_st_o       (wr_st),
    .busy_o        (busy_o),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_addr_o    (rsp_addr_o),
    .rsp_oom_o     (rsp_oom_o),
    .rsp_err_o     (rsp_err_o)
  );
endmodule

// File: tb/tb_buddy_alloc.sv
`timescale 1ns/1ps
module tb_buddy_alloc;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_free = 1'b0;
  logic [ADDR_W:0]   req_size = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              busy, rsp_valid, rsp_oom, rsp_err;
  logic [ADDR_W-1:0] rsp_addr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  buddy_alloc #(.ADDR_W(ADDR_W)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_free_i  (req_free),
    .req_size_i  (req_size),
    .req_addr_i  (req_addr),
    .busy_o      (busy),
    .rsp_valid_o (rsp_valid),
    .rsp_addr_o  (rsp_addr),
    .rsp_oom_o   (rsp_oom),
    .rsp_err_o   (rsp_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit is_free, input int size, input int addr,
                       input string req);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_free  = is_free;
    req_size  = (ADDR_W+1)'(size);
    req_addr  = ADDR_W'(addr);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, req, "busy after accept", int'(busy), 1);
    while (!rsp_valid && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, req, "response arrived", int'(rsp_valid), 1);
  endtask

  task automatic do_alloc(input int size, input int exp_addr, input bit exp_oom,
                          input string req);
    issue(1'b0, size, 0, req);
    chk(rsp_oom == exp_oom, req, "oom flag", int'(rsp_oom), int'(exp_oom));
    chk(rsp_err == 1'b0, req, "err flag on alloc", int'(rsp_err), 0);
    if (!exp_oom)
      chk(int'(rsp_addr) == exp_addr, req, "grant address", int'(rsp_addr), exp_addr);
  endtask

  task automatic do_free(input int addr, input bit exp_err, input string req);
    issue(1'b1, 0, addr, req);
    chk(rsp_err == exp_err, req, "err flag", int'(rsp_err), int'(exp_err));
    chk(rsp_oom == 1'b0, req, "oom flag on free", int'(rsp_oom), 0);
  endtask

  task automatic t_reset();
    // R1
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    do_alloc(1024, 0, 1'b0, "R1");
    do_free(0, 1'b0, "R1");
  endtask

  task automatic t_sequence();
    do_alloc(70, 0, 1'b0, "R2");
    do_alloc(35, 128, 1'b0, "R4");
    do_alloc(80, 256, 1'b0, "R3");
    do_free(0, 1'b0, "R3");
    do_alloc(60, 192, 1'b0, "R3");
    do_free(128, 1'b0, "R5");
    do_free(192, 1'b0, "R5");
    do_free(256, 1'b0, "R5");
    do_alloc(1024, 0, 1'b0, "R5");
    do_free(0, 1'b0, "R5");
  endtask

  task automatic t_oom();
    do_alloc(1024, 0, 1'b0, "R6");
    do_alloc(1, 0, 1'b1, "R6");
    do_free(0, 1'b0, "R6");
    do_alloc(2000, 0, 1'b1, "R6");
    do_alloc(512, 0, 1'b0, "R6");
    do_alloc(600, 0, 1'b1, "R6");
    do_alloc(512, 512, 1'b0, "R6");
    do_free(0, 1'b0, "R6");
    do_free(512, 1'b0, "R6");
    do_alloc(1024, 0, 1'b0, "R6");
    do_free(0, 1'b0, "R6");
  endtask

  task automatic t_bad_free();
    do_alloc(64, 0, 1'b0, "R7");
    do_free(32, 1'b1, "R7");
    do_free(64, 1'b1, "R7");
    do_free(0, 1'b0, "R7");
    do_free(0, 1'b1, "R7");
    do_alloc(1024, 0, 1'b0, "R7");
    do_free(0, 1'b0, "R7");
  endtask

  task automatic t_frag();
    do_alloc(65, 0, 1'b0, "R10");
    do_alloc(0, 128, 1'b0, "R2");
    do_alloc(1, 129, 1'b0, "R3");
    do_alloc(2, 130, 1'b0, "R2");
    do_free(129, 1'b0, "R5");
    do_free(128, 1'b0, "R5");
    do_free(130, 1'b0, "R5");
    do_free(0, 1'b0, "R5");
    do_alloc(1024, 0, 1'b0, "R5");
    do_free(0, 1'b0, "R5");
  endtask

  task automatic t_align();
    do_alloc(3, 0, 1'b0, "R9");
    do_alloc(16, 16, 1'b0, "R9");
    chk((int'(rsp_addr) % 16) == 0, "R9", "16-unit alignment", int'(rsp_addr) % 16, 0);
    do_alloc(4, 4, 1'b0, "R9");
    do_alloc(8, 8, 1'b0, "R9");
    do_alloc(2, 32, 1'b0, "R4");
    do_free(0, 1'b0, "R9");
    do_free(16, 1'b0, "R9");
    do_free(4, 1'b0, "R9");
    do_free(8, 1'b0, "R9");
    do_free(32, 1'b0, "R9");
    do_alloc(1024, 0, 1'b0, "R9");
    do_free(0, 1'b0, "R9");
  endtask

  task automatic t_busy();
    int seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_free = 1'b0; req_size = 1; req_addr = '0;
    @(negedge clk);
    chk(busy == 1'b1, "R8", "busy after accept", int'(busy), 1);
    while (!rsp_valid) begin
      req_valid = 1'b1; req_free = 1'b0; req_size = 1024;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(busy == 1'b0, "R8", "busy low with response", int'(busy), 0);
    chk(int'(rsp_addr) == 0, "R8", "grant address", int'(rsp_addr), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (rsp_valid || busy) seen++;
    end
    chk(seen == 0, "R8", "no response to request raised while busy", seen, 0);
    do_alloc(1, 1, 1'b0, "R8");
    do_free(1, 1'b0, "R8");
    do_free(0, 1'b0, "R8");
    do_alloc(1024, 0, 1'b0, "R8");
    do_free(0, 1'b0, "R8");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequence();
    t_oom();
    t_bad_free();
    t_frag();
    t_align();
    t_busy();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule